// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the read and write strobes of a parallel ATA channel for programmed-I/O and multiword-DMA style word transfers. A requester presents one burst at a time: a direction flag, a select between task-file register access and data access, and a word count. The generator accepts the burst only while idle. It then runs one setup interval, followed by an active (strobe low) phase and an inactive (strobe high) phase for each word. A single-cycle completion pulse closes the burst.

All phase lengths come from a 32-bit per-device timing word. Task-file accesses and data accesses each have their own active, inactive and setup fields. Each field gives a length of its value plus one clock cycles. The timing word is captured when a burst is accepted. Its top four mode-enable bits are status only and have no effect here.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is held and after its release, both strobes are high, `busy` is low and `burst_done` is low.
- R2: `req_ack` is high in exactly those cycles where `req` is high and the generator is idle. A request made while `busy` is high is ignored and leaves the running burst unchanged.
- R3: After acceptance, both strobes stay high for setup+1 cycles before the first word only. The setup field is bits 21:19 for data accesses (`req_taskfile`=0) and bits 24:22 for task-file accesses (`req_taskfile`=1).
- R4: Each word's strobe is low for active+1 cycles. The active field is bits 7:4 for data and bits 15:12 for task-file accesses.
- R5: After each active phase the strobe is high for inactive+1 cycles, and the next word starts only after that. The inactive field is bits 3:0 for data and bits 11:8 for task-file accesses.
- R6: With `req_write`=1 only `wr_strobe_n` goes low. With `req_write`=0 only `rd_strobe_n` goes low. The two are never low together.
- R7: A `req_words` value of N runs N+1 words.
- R8: `busy` is high from the cycle after acceptance through a one-cycle `burst_done` pulse. That pulse follows the last inactive phase, with both strobes high, and the generator is idle in the next cycle.
- R9: `timing_reg`, `req_write` and `req_taskfile` are sampled at acceptance. Changes during a burst do not affect it.
- R10: Bits 31:28, 27:25 and 18:16 of `timing_reg` have no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Burst request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_taskfile | input | 1 | 1 = task-file timing fields, 0 = data timing fields |
| req_words | input | CNT_W | Words in the burst minus one |
| timing_reg | input | TREG_W | Per-device timing word |
| req_ack | output | 1 | Request accepted this cycle |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Burst in progress |
| burst_done | output | 1 | One-cycle end-of-burst pulse |

## Verification
A wrong phase count or a field taken from the wrong bit slice shows up on the strobe pins in the first word of a burst. The strobe edge lands one or more cycles away from the reference, or the setup gap has the wrong length. A word counter that is off by one moves or loses the `burst_done` pulse at the end of the burst. A stale latched direction or timing value appears in the first word after a mid-burst change. Because the bench compares every output on every cycle, each of these faults is caught in the cycle where it first becomes visible.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

   // fixed layout of the timing word (decoded by this block)
   localparam int PHASE_FW       = 4;
   localparam int SETUP_FW       = 3;
   localparam int DAT_RECOV_LSB  = 0;
   localparam int DAT_ACT_LSB    = 4;
   localparam int TF_RECOV_LSB   = 8;
   localparam int TF_ACT_LSB     = 12;
   localparam int DAT_SETUP_LSB  = 19;
   localparam int TF_SETUP_LSB   = 22;
   localparam int TREG_MIN_W     = 25;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ACTIVE,
      ST_RECOVER,
      ST_DONE
   } pio_state_e;

   typedef enum logic [1:0] {
      LD_SETUP,
      LD_ACT,
      LD_RECOV
   } phase_src_e;

   typedef struct packed {
      logic [PHASE_FW-1:0] act;
      logic [PHASE_FW-1:0] recov;
      logic [SETUP_FW-1:0] setup;
   } phase_fields_t;

endpackage

// File: rtl/pio_field_select.sv
module pio_field_select
   import pio_strobe_pkg::*;
#(
   parameter int TREG_W = 32
) (
   input  logic [TREG_W-1:0] timing_reg,
   input  logic              taskfile,
   output phase_fields_t     fields
);

   phase_fields_t dat_f;
   phase_fields_t tf_f;

   always_comb begin
      dat_f.act   = timing_reg[DAT_ACT_LSB   +: PHASE_FW];
      dat_f.recov = timing_reg[DAT_RECOV_LSB +: PHASE_FW];
      dat_f.setup = timing_reg[DAT_SETUP_LSB +: SETUP_FW];
      tf_f.act    = timing_reg[TF_ACT_LSB    +: PHASE_FW];
      tf_f.recov  = timing_reg[TF_RECOV_LSB  +: PHASE_FW];
      tf_f.setup  = timing_reg[TF_SETUP_LSB  +: SETUP_FW];
      fields      = taskfile ? tf_f : dat_f;
   end

   // bits this block does not decode (mode enables, spare fields)
   generate
      if (TREG_W > TREG_MIN_W) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^timing_reg[TREG_W-1:TREG_MIN_W];
      end
   endgenerate
   logic unused_mid;
   assign unused_mid = ^timing_reg[18:16];

endmodule

// File: rtl/pio_down_counter.sv
module pio_down_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         is_zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm
   import pio_strobe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       ph_zero,
   input  logic       wd_zero,
   output pio_state_e state,
   output logic       ph_load,
   output phase_src_e ph_src,
   output logic       ph_dec,
   output logic       wd_load,
   output logic       wd_dec
);

   pio_state_e nxt;

   always_comb begin
      nxt     = state;
      ph_load = 1'b0;
      ph_src  = LD_SETUP;
      ph_dec  = 1'b0;
      wd_load = 1'b0;
      wd_dec  = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               nxt     = ST_SETUP;
               ph_load = 1'b1;
               ph_src  = LD_SETUP;
               wd_load = 1'b1;
            end
         end
         ST_SETUP: begin
            if (ph_zero) begin
               nxt     = ST_ACTIVE;
               ph_load = 1'b1;
               ph_src  = LD_ACT;
            end else begin
               ph_dec = 1'b1;
            end
         end
         ST_ACTIVE: begin
            if (ph_zero) begin
               nxt     = ST_RECOVER;
               ph_load = 1'b1;
               ph_src  = LD_RECOV;
            end else begin
               ph_dec = 1'b1;
            end
         end
         ST_RECOVER: begin
            if (ph_zero) begin
               if (wd_zero) begin
                  nxt = ST_DONE;
               end else begin
                  nxt     = ST_ACTIVE;
                  ph_load = 1'b1;
                  ph_src  = LD_ACT;
                  wd_dec  = 1'b1;
               end
            end else begin
               ph_dec = 1'b1;
            end
         end
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
   import pio_strobe_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int TREG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_write,
   input  logic              req_taskfile,
   input  logic [CNT_W-1:0]  req_words,
   input  logic [TREG_W-1:0] timing_reg,
   output logic              req_ack,
   output logic              rd_strobe_n,
   output logic              wr_strobe_n,
   output logic              busy,
   output logic              burst_done
);

   localparam int PH_W = (PHASE_FW > SETUP_FW) ? PHASE_FW : SETUP_FW;

   generate
      if (TREG_W < TREG_MIN_W) begin : g_bad_treg
         $error("TREG_W must cover the setup fields");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   pio_state_e    state;
   phase_fields_t sel_f;
   phase_fields_t lat_f;
   logic          lat_write;
   logic          start;
   logic          ph_load, ph_dec, ph_zero;
   logic          wd_load, wd_dec, wd_zero;
   phase_src_e    ph_src;
   logic [PH_W-1:0] ph_val;

   assign start = req && (state == ST_IDLE);

   pio_field_select #(.TREG_W(TREG_W)) u_sel (
      .timing_reg (timing_reg),
      .taskfile   (req_taskfile),
      .fields     (sel_f)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_f     <= '0;
         lat_write <= 1'b0;
      end else if (start) begin
         lat_f     <= sel_f;
         lat_write <= req_write;
      end
   end

   always_comb begin
      unique case (ph_src)
         LD_ACT:   ph_val = PH_W'(lat_f.act);
         LD_RECOV: ph_val = PH_W'(lat_f.recov);
         default:  ph_val = PH_W'(sel_f.setup);
      endcase
   end

   pio_strobe_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ph_zero (ph_zero),
      .wd_zero (wd_zero),
      .state   (state),
      .ph_load (ph_load),
      .ph_src  (ph_src),
      .ph_dec  (ph_dec),
      .wd_load (wd_load),
      .wd_dec  (wd_dec)
   );

   pio_down_counter #(.W(PH_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .dec      (ph_dec),
      .is_zero  (ph_zero)
   );

   pio_down_counter #(.W(CNT_W)) u_words (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wd_load),
      .load_val (req_words),
      .dec      (wd_dec),
      .is_zero  (wd_zero)
   );

   assign req_ack     = start;
   assign busy        = (state != ST_IDLE);
   assign burst_done  = (state == ST_DONE);
   assign rd_strobe_n = !((state == ST_ACTIVE) && !lat_write);
   assign wr_strobe_n = !((state == ST_ACTIVE) &&  lat_write);

endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ack,
   input logic rd_strobe_n,
   input logic wr_strobe_n,
   input logic busy,
   input logic burst_done
);

   a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_strobe_n && !wr_strobe_n));

   a_r2_ack_enters_setup: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> (busy && !burst_done && rd_strobe_n && wr_strobe_n));

   a_r2_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ack);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |=> (!burst_done && !busy));

   a_r8_done_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> (busy && rd_strobe_n && wr_strobe_n));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rd_strobe_n && wr_strobe_n && !burst_done));

   a_r4_rd_fall_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_strobe_n) |-> $past(busy));

   a_r4_wr_fall_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_strobe_n) |-> $past(busy));

endmodule

bind pio_strobe_gen pio_strobe_gen_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ack     (req_ack),
   .rd_strobe_n (rd_strobe_n),
   .wr_strobe_n (wr_strobe_n),
   .busy        (busy),
   .burst_done  (burst_done)
);

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_write = 1'b0;
   logic        req_taskfile = 1'b0;
   logic [7:0]  req_words = '0;
   logic [31:0] timing_reg = '0;
   logic        req_ack, rd_strobe_n, wr_strobe_n, busy, burst_done;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   bit reported = 1'b0;
   string scen = "R1";

   // expected {busy, done, wr_n, rd_n} per cycle, with requirement tag
   logic [3:0] q_exp[$];
   string      q_tag[$];

   always #10 clk = ~clk;

   pio_strobe_gen u_dut (
      .clk (clk), .rst_n (rst_n), .req (req), .req_write (req_write),
      .req_taskfile (req_taskfile), .req_words (req_words),
      .timing_reg (timing_reg), .req_ack (req_ack),
      .rd_strobe_n (rd_strobe_n), .wr_strobe_n (wr_strobe_n),
      .busy (busy), .burst_done (burst_done)
   );

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         miscompares++;
         $display("FAIL watchdog: got cycle %0d expected fewer than 150000", cyc);
         report();
      end
   end

   task automatic cmp(input logic [3:0] exp, input string tag);
      logic [3:0] got;
      got = {busy, burst_done, wr_strobe_n, rd_strobe_n};
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s (%s) cycle %0d: got busy/done/wr_n/rd_n=%b expected %b",
                  tag, scen, cyc, got, exp);
      end
   endtask

   task automatic push_burst(input logic w, input logic tf, input int cnt,
                             input logic [31:0] tm);
      int a, i, s;
      a = tf ? int'(tm[15:12]) : int'(tm[7:4]);
      i = tf ? int'(tm[11:8])  : int'(tm[3:0]);
      s = tf ? int'(tm[24:22]) : int'(tm[21:19]);
      for (int k = 0; k <= s; k++) begin q_exp.push_back(4'b1011); q_tag.push_back("R3"); end
      for (int n = 0; n <= cnt; n++) begin
         for (int k = 0; k <= a; k++) begin
            q_exp.push_back(w ? 4'b1001 : 4'b1010); q_tag.push_back("R4");
         end
         for (int k = 0; k <= i; k++) begin q_exp.push_back(4'b1011); q_tag.push_back("R5"); end
      end
      q_exp.push_back(4'b1111); q_tag.push_back("R8");
   endtask

   // one cycle: compare at negedge, then drive inputs for the next edge
   task automatic step(input logic r, input logic w, input logic tf,
                       input logic [7:0] cnt, input logic [31:0] tm);
      bit was_idle;
      @(negedge clk);
      was_idle = (q_exp.size() == 0);
      if (was_idle) cmp(4'b0011, "R8");
      else begin
         logic [3:0] e; string t;
         e = q_exp.pop_front(); t = q_tag.pop_front();
         cmp(e, t);
      end
      req = r; req_write = w; req_taskfile = tf; req_words = cnt; timing_reg = tm;
      #1;
      vectors++;
      if (req_ack !== (r && was_idle)) begin
         miscompares++;
         $display("FAIL R2 (%s): got req_ack=%b expected %b", scen, req_ack, r && was_idle);
      end
      if (r && was_idle) push_burst(w, tf, int'(cnt), tm);
   endtask

   // mode 0: quiet; 1: timing/direction change mid-burst (R9); 2: requests held while busy (R2)
   task automatic burst(input logic w, input logic tf, input logic [7:0] cnt,
                        input logic [31:0] tm, input int mode);
      step(1'b1, w, tf, cnt, tm);
      while (q_exp.size() > 0)
         step(mode == 2, (mode != 0) ? ~w : w, (mode != 0) ? ~tf : tf,
              cnt + 8'd3, (mode != 0) ? ~tm : tm);
      step(1'b0, w, tf, cnt, tm);
   endtask

   initial begin
      // R1: reset state
      repeat (3) begin @(negedge clk); cmp(4'b0011, "R1"); end
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, 8'd0, 32'h0);
      scen = "R3";  burst(1'b0, 1'b0, 8'd0, 32'h0010_0021, 0);   // data read, setup 2
      scen = "R7";  burst(1'b1, 1'b0, 8'd2, 32'h0008_0013, 0);   // data write, 3 words
      scen = "R10"; burst(1'b0, 1'b1, 8'd1, 32'hF1C7_3452, 0);   // task-file read, flags set
      scen = "R6";  burst(1'b1, 1'b1, 8'd0, 32'h0000_0000, 0);   // minimum timings
      scen = "R5";  burst(1'b0, 1'b0, 8'd1, 32'h0038_00FF, 0);   // max data fields
      scen = "R4";  burst(1'b1, 1'b1, 8'd0, 32'h01C0_FF00, 0);   // max task-file fields
      scen = "R9";  burst(1'b0, 1'b0, 8'd2, 32'h0008_0012, 1);
      scen = "R2";  burst(1'b1, 1'b1, 8'd1, 32'h0040_2100, 2);
      scen = "R8";  step(1'b1, 1'b0, 1'b1, 8'd0, 32'h0000_1101); // back to back
      while (q_exp.size() > 0) step(1'b0, 1'b0, 1'b0, 8'd0, 32'h0);
      step(1'b1, 1'b1, 1'b0, 8'd1, 32'h0000_0031);
      while (q_exp.size() > 0) step(1'b0, 1'b0, 1'b0, 8'd0, 32'h0);
      scen = "R7";
      for (int n = 0; n < 24; n++)
         burst(1'($urandom), 1'($urandom), 8'($urandom_range(0, 3)),
               $urandom, int'($urandom_range(0, 2)));
      repeat (3) step(1'b0, 1'b0, 1'b0, 8'd0, 32'h0);
      report();
   end

endmodule